// File: doc/BRIEF.md
# Serial EEPROM Configuration Image Loader

This block runs once after reset. It fetches a 28-byte configuration image from a serial EEPROM over a two-wire bus and checks the image against a seeded XOR checksum. If the image is good, it hands the data words to a register bank. A strap input decides whether a load happens at all. When the strap is low the block stays off the bus and signals completion straight away, so the register bank keeps its default values.

The block contains a small bit-level bus master. The master only pulls SCL and SDA low or releases them. A clock-enable divider splits each bus bit into four equal phases.

One transaction does the whole read:
- It sets the EEPROM's internal pointer to the image base address.
- It issues a repeated start.
- It reads all 28 bytes in one sequential burst.

Bytes are paired into 16-bit words, with the even-address byte as the low half. The first 13 words are data and the 14th word is the checksum. The data words are held inside the block until the checksum agrees, so a corrupt image never reaches the register bank.

Two events count as a failed attempt: a checksum mismatch, or a missing acknowledge on a control or address byte. After a failed attempt the whole read is started again. After 50 failed attempts the block gives up. It commits no words and still raises the done pulse, so the target can run with default values.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: With `cfgStrap` low in the first cycle after reset, the block never pulls SCL or SDA low. It raises `donePulse` within two clock cycles of reset release, with `cfgValid` low and no word strobes.
- R2: Each attempt sends the following on the bus, in this order:
  - a START;
  - control byte 0xA0 (device address 0x50, write);
  - address byte 0x04, then address byte 0x00 (high byte first);
  - a repeated START;
  - control byte 0xA1 (device address 0x50, read).
- R3: After the read control byte, exactly 28 bytes are read in one sequential burst. The master acknowledges the first 27 and not-acknowledges the 28th, then issues a STOP.
- R4: Word k (k = 0..13) is formed from image bytes 2k and 2k+1. Byte 2k is bits 7:0 and byte 2k+1 is bits 15:8.
- R5: The image passes when 0xAAAA XOR words 0 through 12 equals word 13. Words are emitted only after a pass.
- R6: A checksum mismatch starts a full new attempt, beginning again with the START of R2.
- R7: A missing acknowledge on any control or address byte ends the attempt with a STOP. It counts as a failed attempt under the same retry limit.
- R8: After 50 failed attempts, the block commits no words and raises `donePulse` with `cfgValid` low.
- R9: On a pass, the block emits words 0 through 12 on `wordWe`/`wordIdx`/`wordData` in ascending index order. `donePulse` is a single-cycle pulse and comes with `cfgValid` high, and `cfgValid` stays high afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgStrap | input | 1 | Load enable, sampled in the first cycle after reset |
| sdaIn | input | 1 | Resolved level of the SDA line |
| sclLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaLow | output | 1 | 1 pulls SDA low, 0 releases it |
| wordWe | output | 1 | Strobe for one configuration word |
| wordIdx | output | 4 | Index of the word being written (0..12) |
| wordData | output | 16 | Configuration word value |
| donePulse | output | 1 | One-cycle pulse when loading is finished |
| cfgValid | output | 1 | High once a checked image has been committed |

## Verification
The hardest state to reach from the ports is the give-up path. It needs fifty consecutive bad attempts, each of which must still be a complete and well-formed bus transaction. The bench's EEPROM model flips one bit of one image byte on a programmable number of read bursts. The model can also refuse to acknowledge the write control byte a given number of times. With these two knobs the same model drives a recovery after a few bad checksums, a recovery after refused acknowledges, and full exhaustion of the retry limit. In every case the bench counts the read bursts seen on the bus.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_START,
    ST_WRITE,
    ST_READ,
    ST_STOP,
    ST_CHECK,
    ST_EMIT,
    ST_FINISH,
    ST_HALT
  } ldState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic clearSum;   // start of a fresh attempt
    logic sampleBit;  // shift one SDA bit into the receive register
    logic storeByte;  // a full byte has been received
    logic emitWord;   // present the next stored word to the register bank
  } dpStrobe_t;

endpackage

// File: rtl/cfgld_dpath.sv
module cfgld_dpath
  import cfgld_pkg::*;
#(
  parameter int          IMG_BYTES = 28,
  parameter logic [15:0] CK_SEED   = 16'hAAAA
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  dpStrobe_t                            strb,
  input  logic                                 sdaIn,
  output logic                                 sumOk,
  output logic                                 emitLast,
  output logic                                 wordWe,
  output logic [$clog2(IMG_BYTES/2-1)-1:0]     wordIdx,
  output logic [15:0]                          wordData
);

  localparam int NUM_WORDS  = IMG_BYTES / 2;
  localparam int DATA_WORDS = NUM_WORDS - 1;
  localparam int IDX_W      = $clog2(DATA_WORDS);
  localparam int BC_W       = $clog2(IMG_BYTES + 1);
  localparam int SEL_W      = BC_W - 1;

  logic [7:0]       rxShift;
  logic [7:0]       lowByte;
  logic [BC_W-1:0]  byteCnt;
  logic [15:0]      sumAcc;
  logic [15:0]      chkWord;
  logic [IDX_W-1:0] emitIdx;
  logic [SEL_W-1:0] wordSel;
  logic [15:0]      newWord;
  logic             oddByte;
  logic             isChk;
  logic [15:0]      slotVal [DATA_WORDS];

  assign wordSel  = byteCnt[BC_W-1:1];
  assign oddByte  = byteCnt[0];
  assign newWord  = {rxShift, lowByte};
  assign isChk    = (wordSel == SEL_W'(DATA_WORDS));
  assign sumOk    = (byteCnt == BC_W'(IMG_BYTES)) && (sumAcc == chkWord);
  assign emitLast = (emitIdx == IDX_W'(DATA_WORDS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      lowByte  <= '0;
      byteCnt  <= '0;
      sumAcc   <= CK_SEED;
      chkWord  <= ~CK_SEED;
      emitIdx  <= '0;
      wordWe   <= 1'b0;
      wordIdx  <= '0;
      wordData <= '0;
    end else begin
      if (strb.sampleBit) rxShift <= {rxShift[6:0], sdaIn};
      if (strb.clearSum) begin
        byteCnt <= '0;
        sumAcc  <= CK_SEED;
        chkWord <= ~CK_SEED;
        emitIdx <= '0;
      end else if (strb.storeByte) begin
        byteCnt <= byteCnt + 1'b1;
        if (!oddByte)  lowByte <= rxShift;
        else if (isChk) chkWord <= newWord;
        else            sumAcc  <= sumAcc ^ newWord;
      end
      wordWe <= strb.emitWord;
      if (strb.emitWord) begin
        wordData <= slotVal[emitIdx];
        wordIdx  <= emitIdx;
        emitIdx  <= emitIdx + 1'b1;
      end
    end
  end

  // One holding register per data word, written when its odd byte arrives.
  for (genvar g = 0; g < DATA_WORDS; g++) begin : g_slot
    logic [15:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotQ <= '0;
      else if (strb.storeByte && oddByte && (wordSel == SEL_W'(g))) slotQ <= newWord;
    end
    assign slotVal[g] = slotQ;
  end

  p_emit_after_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitWord |-> sumOk);

  p_emit_ascend_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordWe && $past(wordWe)) |-> (wordIdx == $past(wordIdx) + 1'b1));

  p_byte_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= BC_W'(IMG_BYTES));

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int          CLK_DIV   = 8,
  parameter int          MAX_TRIES = 50,
  parameter logic [6:0]  DEV_ADDR  = 7'h50,
  parameter logic [15:0] IMG_BASE  = 16'h0400,
  parameter int          IMG_BYTES = 28
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgStrap,
  input  logic      sdaIn,
  input  logic      sumOk,
  input  logic      emitLast,
  output dpStrobe_t strb,
  output logic      sclLow,
  output logic      sdaLow,
  output logic      donePulse,
  output logic      cfgValid
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int RD_W  = $clog2(IMG_BYTES);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [RD_W-1:0]  RD_LAST  = RD_W'(IMG_BYTES - 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

  ldState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [1:0]       phase;
  logic [3:0]       bitCnt;
  logic [1:0]       wrIdx;
  logic [RD_W-1:0]  rdCnt;
  logic [TRY_W-1:0] tries;
  logic             nackSeen;
  logic             attemptBad;
  logic             strapOff;
  logic [7:0]       txByte;
  logic [2:0]       bitSel;
  logic             tick;
  logic             stepEnd;
  logic             busActive;
  logic             failNow;

  assign tick      = (divCnt == DIV_LAST);
  assign stepEnd   = tick && (phase == 2'd3);
  assign busActive = (state == ST_START) || (state == ST_WRITE) ||
                     (state == ST_READ)  || (state == ST_STOP);
  assign failNow   = ((state == ST_STOP) && stepEnd && attemptBad) ||
                     ((state == ST_CHECK) && !sumOk);
  assign bitSel    = 3'd7 - bitCnt[2:0];
  assign donePulse = (state == ST_FINISH);

  always_comb begin
    case (wrIdx)
      2'd0:    txByte = {DEV_ADDR, 1'b0};
      2'd1:    txByte = IMG_BASE[15:8];
      2'd2:    txByte = IMG_BASE[7:0];
      default: txByte = {DEV_ADDR, 1'b1};
    endcase
  end

  always_comb begin
    strb.clearSum  = ((state == ST_BOOT) && cfgStrap) || (failNow && (tries != TRY_LAST));
    strb.sampleBit = (state == ST_READ) && tick && (phase == 2'd2) && !bitCnt[3];
    strb.storeByte = (state == ST_READ) && stepEnd && bitCnt[3];
    strb.emitWord  = (state == ST_EMIT);
  end

  // Open-drain drive: four phases per bit, SCL high during phases 1 and 2.
  always_comb begin
    sclLow = 1'b0;
    sdaLow = 1'b0;
    case (state)
      ST_START: begin
        case (phase)
          2'd0: sclLow = (wrIdx == 2'd3);
          2'd1: ;
          2'd2: sdaLow = 1'b1;
          default: begin sclLow = 1'b1; sdaLow = 1'b1; end
        endcase
      end
      ST_WRITE: begin
        sclLow = (phase == 2'd0) || (phase == 2'd3);
        sdaLow = !bitCnt[3] && !txByte[bitSel];
      end
      ST_READ: begin
        sclLow = (phase == 2'd0) || (phase == 2'd3);
        sdaLow = bitCnt[3] && (rdCnt != RD_LAST);
      end
      ST_STOP: begin
        sclLow = (phase == 2'd0);
        sdaLow = (phase <= 2'd1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_BOOT;
      divCnt     <= '0;
      phase      <= '0;
      bitCnt     <= '0;
      wrIdx      <= '0;
      rdCnt      <= '0;
      tries      <= '0;
      nackSeen   <= 1'b0;
      attemptBad <= 1'b0;
      cfgValid   <= 1'b0;
      strapOff   <= 1'b0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (busActive && tick) phase <= phase + 2'd1;
      case (state)
        ST_BOOT: begin
          if (cfgStrap) state <= ST_START;
          else begin
            strapOff <= 1'b1;
            state    <= ST_FINISH;
          end
        end
        ST_START: if (stepEnd) begin
          state  <= ST_WRITE;
          bitCnt <= '0;
        end
        ST_WRITE: begin
          if (tick && (phase == 2'd2) && bitCnt[3]) nackSeen <= sdaIn;
          if (stepEnd) begin
            if (!bitCnt[3]) bitCnt <= bitCnt + 1'b1;
            else begin
              bitCnt <= '0;
              if (nackSeen) begin
                attemptBad <= 1'b1;
                state      <= ST_STOP;
              end else if (wrIdx == 2'd2) begin
                wrIdx <= 2'd3;
                state <= ST_START;
              end else if (wrIdx == 2'd3) begin
                rdCnt <= '0;
                state <= ST_READ;
              end else begin
                wrIdx <= wrIdx + 1'b1;
              end
            end
          end
        end
        ST_READ: if (stepEnd) begin
          if (!bitCnt[3]) bitCnt <= bitCnt + 1'b1;
          else begin
            bitCnt <= '0;
            if (rdCnt == RD_LAST) begin
              attemptBad <= 1'b0;
              state      <= ST_STOP;
            end else begin
              rdCnt <= rdCnt + 1'b1;
            end
          end
        end
        ST_STOP:  if (stepEnd && !attemptBad) state <= ST_CHECK;
        ST_CHECK: if (sumOk) begin
          cfgValid <= 1'b1;
          state    <= ST_EMIT;
        end
        ST_EMIT:   if (emitLast) state <= ST_FINISH;
        ST_FINISH: state <= ST_HALT;
        default: ;
      endcase
      if (failNow) begin
        if (tries == TRY_LAST) state <= ST_FINISH;
        else begin
          tries <= tries + 1'b1;
          wrIdx <= '0;
          state <= ST_START;
        end
      end
    end
  end

  p_quiet_strapoff_r1: assert property (@(posedge clk) disable iff (!rstN)
    strapOff |-> (!sclLow && !sdaLow));

  p_single_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  p_try_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    tries < TRY_W'(MAX_TRIES));

  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid);

  p_giveup_invalid_r8: assert property (@(posedge clk) disable iff (!rstN)
    failNow |=> !cfgValid);

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int          CLK_DIV   = 8,
  parameter int          MAX_TRIES = 50,
  parameter logic [6:0]  DEV_ADDR  = 7'h50,
  parameter logic [15:0] IMG_BASE  = 16'h0400,
  parameter int          IMG_BYTES = 28,
  parameter logic [15:0] CK_SEED   = 16'hAAAA
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cfgStrap,
  input  logic                             sdaIn,
  output logic                             sclLow,
  output logic                             sdaLow,
  output logic                             wordWe,
  output logic [$clog2(IMG_BYTES/2-1)-1:0] wordIdx,
  output logic [15:0]                      wordData,
  output logic                             donePulse,
  output logic                             cfgValid
);

  dpStrobe_t strb;
  logic      sumOk;
  logic      emitLast;

  cfgld_ctrl #(
    .CLK_DIV(CLK_DIV), .MAX_TRIES(MAX_TRIES), .DEV_ADDR(DEV_ADDR),
    .IMG_BASE(IMG_BASE), .IMG_BYTES(IMG_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgStrap(cfgStrap), .sdaIn(sdaIn),
    .sumOk(sumOk), .emitLast(emitLast), .strb(strb),
    .sclLow(sclLow), .sdaLow(sdaLow), .donePulse(donePulse), .cfgValid(cfgValid)
  );

  cfgld_dpath #(
    .IMG_BYTES(IMG_BYTES), .CK_SEED(CK_SEED)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaIn(sdaIn),
    .sumOk(sumOk), .emitLast(emitLast),
    .wordWe(wordWe), .wordIdx(wordIdx), .wordData(wordData)
  );

endmodule

// File: tb/eeprom_cfg_loader_bench.sv
`timescale 1ns/1ps
module eeprom_cfg_loader_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        cfgStrap = 1'b0;
  logic        slaveLow = 1'b0;
  logic        sclLow, sdaLow, wordWe, donePulse, cfgValid;
  logic [3:0]  wordIdx;
  logic [15:0] wordData;
  logic        sclLine, sdaLine;

  assign sclLine = !sclLow;
  assign sdaLine = !(sdaLow || slaveLow);

  eeprom_cfg_loader #(.CLK_DIV(2)) u_eeprom_cfg_loader (
    .clk(clk), .rstN(rstN), .cfgStrap(cfgStrap), .sdaIn(sdaLine),
    .sclLow(sclLow), .sdaLow(sdaLow), .wordWe(wordWe), .wordIdx(wordIdx),
    .wordData(wordData), .donePulse(donePulse), .cfgValid(cfgValid)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  logic [7:0]  eeImg [28];
  int          nackLeft = 0;
  int          corruptLeft = 0;
  bit          pScl, pSda, active, rdMode, goRead, mAck, ackIt;
  int          bCnt, byteNum, a0Cnt, a1Cnt, refusedCnt, rdBytes, sclFalls, sdaEdges;
  bit          endNack;
  logic [7:0]  sh, txb;
  logic [15:0] eeAddr, addrSeen;

  function automatic logic [7:0] memByte(input logic [15:0] a, input bit flip);
    logic [7:0] v;
    if (a >= 16'h0400 && a <= 16'h041B) v = eeImg[a - 16'h0400];
    else v = 8'hFF;
    if (flip && a == 16'h0405) v = v ^ 8'h10;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pScl = 1; pSda = 1; active = 0; rdMode = 0; goRead = 0; bCnt = 0; byteNum = 0;
      a0Cnt = 0; a1Cnt = 0; refusedCnt = 0; rdBytes = 0; sclFalls = 0; sdaEdges = 0;
      endNack = 0; addrSeen = 16'hFFFF; slaveLow <= 1'b0;
    end else begin
      if (pSda != sdaLine) sdaEdges++;
      if (pScl && !sclLine) sclFalls++;
      if (pScl && sclLine && pSda && !sdaLine) begin
        active = 1; bCnt = 0; byteNum = 0; rdMode = 0; goRead = 0; slaveLow <= 1'b0;
      end else if (pScl && sclLine && !pSda && sdaLine) begin
        active = 0; rdMode = 0; slaveLow <= 1'b0;
      end else if (active && !pScl && sclLine) begin
        if (!rdMode && bCnt < 8) sh = {sh[6:0], sdaLine};
        if (rdMode && bCnt == 8) mAck = !sdaLine;
        bCnt++;
      end else if (active && pScl && !sclLine) begin
        if (bCnt == 8 && !rdMode) begin
          ackIt = 1;
          if (byteNum == 0) begin
            if (sh == 8'hA0) begin
              if (nackLeft > 0) begin nackLeft--; refusedCnt++; ackIt = 0; end
              else a0Cnt++;
            end else if (sh == 8'hA1) begin
              a1Cnt++; goRead = 1;
            end else ackIt = 0;
          end else if (byteNum == 1) eeAddr[15:8] = sh;
          else eeAddr[7:0] = sh;
          byteNum++;
          slaveLow <= ackIt;
        end else if (bCnt == 9) begin
          bCnt = 0;
          if (!rdMode) begin
            slaveLow <= 1'b0;
            if (goRead) begin
              rdMode = 1; addrSeen = eeAddr; rdBytes = 1;
              txb = memByte(eeAddr, corruptLeft > 0); eeAddr++;
              slaveLow <= !txb[7];
            end
          end else if (mAck) begin
            rdBytes++;
            txb = memByte(eeAddr, corruptLeft > 0); eeAddr++;
            slaveLow <= !txb[7];
          end else begin
            slaveLow <= 1'b0; active = 0; endNack = 1;
            if (corruptLeft > 0) corruptLeft--;
          end
        end else if (rdMode && bCnt >= 1 && bCnt <= 7) begin
          slaveLow <= !txb[7 - bCnt];
        end else if (rdMode && bCnt == 8) begin
          slaveLow <= 1'b0;
        end
      end
      pScl = sclLine; pSda = sdaLine;
    end
  end

  // ---------------- scoreboard ----------------
  logic [19:0] expQ [$];

  task automatic pushExpected(input int idx, input logic [15:0] w);
    expQ.push_back({4'(idx), w});
  endtask

  always @(negedge clk) begin
    if (rstN && wordWe) begin
      if (expQ.size() == 0) begin
        check(0, "R9", "unexpected word strobe idx", wordIdx, 0);
      end else begin
        logic [19:0] e;
        e = expQ.pop_front();
        check(wordIdx == e[19:16], "R9", "word index order", wordIdx, e[19:16]);
        check(wordData == e[15:0], "R4", "word value", wordData, e[15:0]);
      end
    end
  end

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles == 195000) begin
      nChecks++; nFails++;
      $display("FAIL R9 watchdog expired: actual %0d expected 0", cycles);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  // ---------------- cases ----------------
  bit doneSeen, validAtDone;
  int doneCyc;

  task automatic runCase(input bit strap, input int nacks, input int corrupts,
                         input int pat, input bit expOk);
    logic [15:0] chk;
    int cyc;
    for (int i = 0; i < 26; i++) begin
      case (pat)
        0:       eeImg[i] = 8'(i * 37 + 5);
        1:       eeImg[i] = 8'h00;
        default: eeImg[i] = 8'(8'hC3 ^ (i * 11));
      endcase
    end
    chk = 16'hAAAA;
    for (int w = 0; w < 13; w++) chk = chk ^ {eeImg[2*w+1], eeImg[2*w]};
    eeImg[26] = chk[7:0];
    eeImg[27] = chk[15:8];
    expQ.delete();
    if (expOk)
      for (int w = 0; w < 13; w++) pushExpected(w, {eeImg[2*w+1], eeImg[2*w]});
    @(negedge clk);
    rstN = 1'b0;
    nackLeft = nacks;
    corruptLeft = corrupts;
    cfgStrap = strap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    doneSeen = 0; validAtDone = 0; doneCyc = 0; cyc = 0;
    while (!doneSeen && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      if (donePulse) begin doneSeen = 1; validAtDone = cfgValid; doneCyc = cyc; end
    end
    @(negedge clk);
    check(!donePulse, "R9", "done pulse is one cycle", donePulse, 0);
    check(doneSeen, "R9", "done pulse seen", doneSeen, 1);
    check(cfgValid == expOk, "R9", "valid after done", cfgValid, expOk);
    check(expQ.size() == 0, "R9", "words left unemitted", expQ.size(), 0);
  endtask

  initial begin
    // Reset state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(!sclLow && !sdaLow, "R1", "bus released in reset", {sclLow, sdaLow}, 0);
    check(!wordWe && !donePulse && !cfgValid, "R9", "outputs idle in reset",
          {wordWe, donePulse, cfgValid}, 0);

    // R1: strap off
    runCase(0, 0, 0, 0, 0);
    check(doneCyc <= 2, "R1", "done latency cycles", doneCyc, 2);
    check(validAtDone == 0, "R1", "valid with strap off", validAtDone, 0);
    check(sclFalls == 0, "R1", "scl falls with strap off", sclFalls, 0);
    check(sdaEdges == 0, "R1", "sda edges with strap off", sdaEdges, 0);

    // Good image, first try: R2 R3 R4 R5 R9
    runCase(1, 0, 0, 0, 1);
    check(validAtDone == 1, "R5", "valid at done on pass", validAtDone, 1);
    check(a0Cnt == 1, "R2", "write control bytes", a0Cnt, 1);
    check(a1Cnt == 1, "R2", "read control bytes", a1Cnt, 1);
    check(addrSeen == 16'h0400, "R2", "start address", addrSeen, 16'h0400);
    check(rdBytes == 28, "R3", "bytes read in burst", rdBytes, 28);
    check(endNack == 1, "R3", "nack on last byte", endNack, 1);

    // Refused acknowledge twice, zero image (checksum word 0xAAAA): R7 R5
    runCase(1, 2, 0, 1, 1);
    check(refusedCnt == 2, "R7", "refused control bytes", refusedCnt, 2);
    check(a0Cnt == 1 && a1Cnt == 1, "R7", "accepted after refusals", a1Cnt, 1);
    check(validAtDone == 1, "R7", "valid after nack retries", validAtDone, 1);

    // Three corrupt bursts then good: R6
    runCase(1, 0, 3, 2, 1);
    check(a1Cnt == 4, "R6", "read bursts with three bad checksums", a1Cnt, 4);
    check(a0Cnt == 4, "R6", "full restarts with write control", a0Cnt, 4);
    check(validAtDone == 1, "R6", "valid after checksum retries", validAtDone, 1);

    // Always corrupt: R8
    runCase(1, 0, 1000, 0, 0);
    check(a1Cnt == 50, "R8", "attempts before giving up", a1Cnt, 50);
    check(validAtDone == 0, "R8", "valid after giving up", validAtDone, 0);
    check(rdBytes == 28, "R3", "last burst length", rdBytes, 28);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule